// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that runs a chain of descriptors kept in memory. Software writes the address of the first descriptor to a base register and then sets the run bit in the status register. The channel reads a four-word descriptor, made of a command word, a source address, a target address and a count word. It then copies data in units of the size the command selects. When that descriptor is done, the channel either follows a link to another descriptor or stops. It stops with the terminated flag set and, if the command asks for it, an interrupt.

Links are relative. The top byte of the count word gives the next descriptor's distance from the base address that was latched at start, counted in 16-byte steps. A chain whose last link points back to offset 0 runs until software stops it, and it never interrupts. A live count register shows how many units of the active descriptor remain. Misaligned addresses and undefined unit codes halt the channel with an error.

Top module: `dma_chain_channel`

## Requirements
- R1: After a start, the channel reads the descriptor at the base address as four words at offsets 0, 4, 8 and 12, in that order. The words are command, source, target and count.
- R2: The command word's bits 10:8 select the unit size: 0=4, 1=1, 2=2, 3=16, 4=32, 5=64, 6=128 bytes. The channel moves count[23:0] units from the source to the target. Units wider than 4 bytes are moved as 32-bit beats. Narrower units are moved as a single byte-lane beat.
- R3: Command bit 23 set makes the source address advance after each beat, and bit 22 does the same for the target address. When a bit is clear, that address stays fixed for the whole descriptor.
- R4: Command bit 0 set makes the channel fetch its next descriptor at the latched base plus 16 × count[31:24] once the current descriptor is finished.
- R5: A descriptor with bit 0 clear ends the chain and sets status bit 3 (terminated). The interrupt is raised only if command bit 1 is set. A linked descriptor never raises it, so a chain looping back to offset 0 never interrupts.
- R6: Register select 2 reads the units still to move for the active descriptor. It falls by one as each unit completes and reads 0 after a chain has ended.
- R7: If the source or target address is not a multiple of the unit size, or the unit code is 7, the descriptor moves no data. Status then reads 0x14 (bit 4 address error, bit 2 halt, bit 0 cleared) and the interrupt is raised.
- R8: Writing a word with bit 0 clear to the status register (select 1) stops the channel, clears all status bits and drops the interrupt. Writing bit 0 set while the channel is idle starts it; status bit 0 reads 1 while running.
- R9: After reset, status, base, live count and interrupt are all 0 and no memory request is made.
- R10: A descriptor whose count is zero moves no data and completes like any other descriptor.
- R11: The base register (select 0) is copied at start. Writing a new base while a chain runs does not change where later links are found.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 base, 1 status, 2 live count |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on regSel) |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | 32 | Word-aligned memory address |
| memWdata | output | 32 | Memory write data |
| memBe | output | 4 | Byte enables for a write |
| memAck | input | 1 | Access accepted; read data valid in the same cycle |
| memRdata | input | 32 | Memory read data |
| irq | output | 1 | Interrupt, level, held until status is cleared |

## Verification
Several properties are checked on every cycle. A fixed address never moves while its increment bit is clear. The live count only ever holds or steps down by one between descriptor loads. An address error always comes with halt and a stopped channel. The interrupt only rises on the same edge that stops the channel.

Other behaviours only show up in whole scenarios, so the bench runs them end to end:
- the bytes that land in memory for each unit size and addressing mode;
- a link chain found through the latched base even after the base register is rewritten;
- a self-looping chain that never interrupts;
- the residue read mid-transfer while a write is held off.

// File: rtl/dma_chain_pkg.sv
`timescale 1ns/1ps
package dma_chain_pkg;
  localparam int WORD_W   = 32;
  localparam int CNT_W    = 24;
  localparam int OFF_W    = WORD_W - CNT_W;
  localparam int BEAT_W   = 5;
  localparam int CMD_LINK = 0;
  localparam int CMD_TIE  = 1;
  localparam int UNIT_LSB = 8;
  localparam int CMD_DINC = 22;
  localparam int CMD_SINC = 23;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_READ, ST_WRITE, ST_END
  } stateT;

  typedef enum logic [1:0] {SEL_DESC, SEL_SRC, SEL_DST} memSelT;

  typedef struct packed {
    logic       startLatch;
    logic       toLink;
    logic       loadWord;
    logic [1:0] wordIdx;
    logic       capData;
    logic       stepAddr;
    logic       decCnt;
    memSelT     memSel;
  } strobeT;

  // returns {invalid, log2(unit bytes)}
  function automatic logic [3:0] decodeUnit(input logic [2:0] code);
    case (code)
      3'd0:    return 4'd2;
      3'd1:    return 4'd0;
      3'd2:    return 4'd1;
      3'd3:    return 4'd4;
      3'd4:    return 4'd5;
      3'd5:    return 4'd6;
      3'd6:    return 4'd7;
      default: return 4'b1000;
    endcase
  endfunction
endpackage

// File: rtl/dma_chain_dp.sv
`timescale 1ns/1ps
module dma_chain_dp
  import dma_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic              regWr,
  input  logic [1:0]        regSel,
  input  logic [WORD_W-1:0] regWdata,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [3:0]        memBe,
  output logic              cmdLink,
  output logic              cmdTie,
  output logic [2:0]        unitLog,
  output logic              unitBad,
  output logic              misAlign,
  output logic              cntZero,
  output logic              cntOne,
  output logic [WORD_W-1:0] baseOut,
  output logic [CNT_W-1:0]  cntOut
);
  logic [WORD_W-1:0] regBase, baseLatched, descPtr, cmdReg, srcAddr, dstAddr, dataReg;
  logic [CNT_W-1:0]  cntReg;
  logic [OFF_W-1:0]  nextOff;
  logic [1:0]        beatLog;
  logic [WORD_W-1:0] beatBytes, alignMask;

  assign {unitBad, unitLog} = decodeUnit(cmdReg[UNIT_LSB +: 3]);
  assign beatLog   = (unitLog > 3'd2) ? 2'd2 : unitLog[1:0];
  assign beatBytes = 32'd1 << beatLog;
  assign alignMask = (32'd1 << unitLog) - 32'd1;
  assign misAlign  = |((srcAddr | dstAddr) & alignMask);
  assign cmdLink   = cmdReg[CMD_LINK];
  assign cmdTie    = cmdReg[CMD_TIE];
  assign cntZero   = (cntReg == '0);
  assign cntOne    = (cntReg == CNT_W'(1));
  assign baseOut   = regBase;
  assign cntOut    = cntReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regBase     <= '0;
      baseLatched <= '0;
      descPtr     <= '0;
      cmdReg      <= '0;
      srcAddr     <= '0;
      dstAddr     <= '0;
      dataReg     <= '0;
      cntReg      <= '0;
      nextOff     <= '0;
    end else begin
      if (regWr && regSel == 2'd0) regBase <= regWdata;
      if (strb.startLatch) begin
        baseLatched <= regBase;
        descPtr     <= regBase;
      end
      if (strb.toLink) descPtr <= baseLatched + {{(WORD_W-OFF_W-4){1'b0}}, nextOff, 4'b0};
      if (strb.loadWord) begin
        case (strb.wordIdx)
          2'd0:    cmdReg  <= memRdata;
          2'd1:    srcAddr <= memRdata;
          2'd2:    dstAddr <= memRdata;
          default: {nextOff, cntReg} <= memRdata;
        endcase
      end
      if (strb.capData) dataReg <= memRdata;
      if (strb.stepAddr) begin
        if (cmdReg[CMD_SINC]) srcAddr <= srcAddr + beatBytes;
        if (cmdReg[CMD_DINC]) dstAddr <= dstAddr + beatBytes;
      end
      if (strb.decCnt) cntReg <= cntReg - CNT_W'(1);
    end
  end

  always_comb begin
    case (strb.memSel)
      SEL_SRC: memAddr = {srcAddr[WORD_W-1:2], 2'b00};
      SEL_DST: memAddr = {dstAddr[WORD_W-1:2], 2'b00};
      default: memAddr = descPtr + {{(WORD_W-4){1'b0}}, strb.wordIdx, 2'b00};
    endcase
    case (beatLog)
      2'd0:    memBe = 4'b0001 << dstAddr[1:0];
      2'd1:    memBe = 4'b0011 << dstAddr[1:0];
      default: memBe = 4'b1111;
    endcase
    memWdata = (dataReg >> {srcAddr[1:0], 3'b000}) << {dstAddr[1:0], 3'b000};
  end

  // R3: a non-incrementing address never moves outside descriptor loads
  assert_src_fixed_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.loadWord) && !$past(cmdReg[CMD_SINC])) |-> $stable(srcAddr));
  assert_dst_fixed_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.loadWord) && !$past(cmdReg[CMD_DINC])) |-> $stable(dstAddr));
  // R6: residue holds or steps down by exactly one unit
  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.loadWord) |-> (cntReg == $past(cntReg)) || (cntReg == $past(cntReg) - CNT_W'(1)));
endmodule

// File: rtl/dma_chain_ctrl.sv
`timescale 1ns/1ps
module dma_chain_ctrl
  import dma_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regSel,
  input  logic              regWbit0,
  input  logic              memAck,
  input  logic              cmdLink,
  input  logic              cmdTie,
  input  logic [2:0]        unitLog,
  input  logic              unitBad,
  input  logic              misAlign,
  input  logic              cntZero,
  input  logic              cntOne,
  output strobeT            strb,
  output logic              memReq,
  output logic              memWe,
  output logic [WORD_W-1:0] statusWord,
  output logic              irq
);
  stateT             state;
  logic [1:0]        wordIdx;
  logic [BEAT_W-1:0] beat, lastBeat;
  logic [BEAT_W:0]   beatsPer;
  logic              chanEn, haltF, termF, errF, irqF;
  logic              statusWr, startCmd, stopCmd;

  assign statusWr = regWr && (regSel == 2'd1);
  assign stopCmd  = statusWr && !regWbit0;
  assign startCmd = statusWr && regWbit0 && (state == ST_IDLE);
  assign beatsPer = (unitLog > 3'd2) ? ({{BEAT_W{1'b0}}, 1'b1} << (unitLog - 3'd2))
                                     : {{BEAT_W{1'b0}}, 1'b1};
  assign lastBeat   = BEAT_W'(beatsPer - 1'b1);
  assign statusWord = {{(WORD_W-5){1'b0}}, errF, termF, haltF, 1'b0, chanEn};
  assign irq        = irqF;

  always_comb begin
    strb         = '0;
    strb.wordIdx = wordIdx;
    strb.memSel  = SEL_DESC;
    memReq       = 1'b0;
    memWe        = 1'b0;
    strb.startLatch = startCmd;
    case (state)
      ST_FETCH: begin
        memReq        = 1'b1;
        strb.loadWord = memAck;
      end
      ST_READ: begin
        memReq       = 1'b1;
        strb.memSel  = SEL_SRC;
        strb.capData = memAck;
      end
      ST_WRITE: begin
        memReq        = 1'b1;
        memWe         = 1'b1;
        strb.memSel   = SEL_DST;
        strb.stepAddr = memAck;
        strb.decCnt   = memAck && (beat == lastBeat);
      end
      ST_END:  strb.toLink = cmdLink;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
      beat    <= '0;
      chanEn  <= 1'b0;
      haltF   <= 1'b0;
      termF   <= 1'b0;
      errF    <= 1'b0;
      irqF    <= 1'b0;
    end else if (stopCmd) begin
      state  <= ST_IDLE;
      chanEn <= 1'b0;
      haltF  <= 1'b0;
      termF  <= 1'b0;
      errF   <= 1'b0;
      irqF   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (startCmd) begin
          state   <= ST_FETCH;
          wordIdx <= '0;
          chanEn  <= 1'b1;
          haltF   <= 1'b0;
          termF   <= 1'b0;
          errF    <= 1'b0;
          irqF    <= 1'b0;
        end
        ST_FETCH: if (memAck) begin
          if (wordIdx == 2'd3) state <= ST_CHECK;
          wordIdx <= wordIdx + 2'd1;
        end
        ST_CHECK: begin
          beat <= '0;
          if (unitBad || misAlign) begin
            errF   <= 1'b1;
            haltF  <= 1'b1;
            chanEn <= 1'b0;
            irqF   <= 1'b1;
            state  <= ST_IDLE;
          end else if (cntZero) state <= ST_END;
          else state <= ST_READ;
        end
        ST_READ: if (memAck) state <= ST_WRITE;
        ST_WRITE: if (memAck) begin
          if (beat == lastBeat) begin
            beat  <= '0;
            state <= cntOne ? ST_END : ST_READ;
          end else begin
            beat  <= beat + 1'b1;
            state <= ST_READ;
          end
        end
        ST_END: begin
          if (cmdLink) begin
            wordIdx <= '0;
            state   <= ST_FETCH;
          end else begin
            termF  <= 1'b1;
            chanEn <= 1'b0;
            irqF   <= cmdTie;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: an address error always leaves the channel halted and stopped
  assert_err_halts_R7: assert property (@(posedge clk) disable iff (!rstN)
    errF |-> (haltF && !chanEn));
  // R5: the interrupt only rises when the channel stops
  assert_irq_at_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqF) |-> !chanEn);
  // R9: an idle channel makes no memory request
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> !memReq || chanEn);
endmodule

// File: rtl/dma_chain_channel.sv
`timescale 1ns/1ps
module dma_chain_channel
  import dma_chain_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [1:0]  regSel,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  output logic [3:0]  memBe,
  input  logic        memAck,
  input  logic [31:0] memRdata,
  output logic        irq
);
  strobeT            strb;
  logic              cmdLink, cmdTie, unitBad, misAlign, cntZero, cntOne;
  logic [2:0]        unitLog;
  logic [WORD_W-1:0] baseOut, statusWord;
  logic [CNT_W-1:0]  cntOut;

  dma_chain_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWbit0(regWdata[0]),
    .memAck(memAck), .cmdLink(cmdLink), .cmdTie(cmdTie), .unitLog(unitLog),
    .unitBad(unitBad), .misAlign(misAlign), .cntZero(cntZero), .cntOne(cntOne),
    .strb(strb), .memReq(memReq), .memWe(memWe), .statusWord(statusWord), .irq(irq)
  );

  dma_chain_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWr(regWr), .regSel(regSel),
    .regWdata(regWdata), .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memBe(memBe), .cmdLink(cmdLink), .cmdTie(cmdTie), .unitLog(unitLog),
    .unitBad(unitBad), .misAlign(misAlign), .cntZero(cntZero), .cntOne(cntOne),
    .baseOut(baseOut), .cntOut(cntOut)
  );

  always_comb begin
    case (regSel)
      2'd0:    regRdata = baseOut;
      2'd1:    regRdata = statusWord;
      2'd2:    regRdata = {{OFF_W{1'b0}}, cntOut};
      default: regRdata = '0;
    endcase
  end
endmodule

// File: tb/dma_chain_channel_bench.sv
`timescale 1ns/1ps
module dma_chain_channel_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN, regWr, memReq, memWe, memAck, irq;
  logic [1:0]  regSel;
  logic [31:0] regWdata, regRdata, memAddr, memWdata, memRdata;
  logic [3:0]  memBe;

  dma_chain_channel u_dma_chain_channel (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memBe(memBe), .memAck(memAck), .memRdata(memRdata), .irq(irq)
  );

  logic [7:0] memB   [0:4095];
  logic [7:0] expMem [0:4095];
  int checks = 0, fails = 0;
  int wrCount = 0, irqRises = 0, stallAt = -1, wrBase = 0, logN = 0;
  logic irqPrev = 1'b0;
  logic [31:0] readLog [4];

  wire [11:0] wa = {memAddr[11:2], 2'b00};
  assign memRdata = {memB[wa + 12'd3], memB[wa + 12'd2], memB[wa + 12'd1], memB[wa]};
  assign memAck   = memReq && !(memWe && ((wrCount - wrBase) == stallAt));

  always @(posedge clk) begin
    irqPrev <= irq;
    if (irq && !irqPrev) irqRises <= irqRises + 1;
    if (memReq && memAck && memWe) begin
      wrCount <= wrCount + 1;
      for (int l = 0; l < 4; l++)
        if (memBe[l]) memB[wa + 12'(l)] <= memWdata[8*l +: 8];
    end
    if (memReq && memAck && !memWe && logN < 4) begin
      readLog[logN] <= memAddr;
      logN <= logN + 1;
    end
  end

  // code, sai, dai, src, dst, count
  localparam int NV = 7;
  localparam logic [47:0] VEC [NV] = '{
    48'h1_1_1_101_803_005,
    48'h2_1_1_102_806_004,
    48'h0_1_1_104_810_006,
    48'h3_1_1_110_820_003,
    48'h6_1_1_180_900_002,
    48'h4_1_0_120_880_003,
    48'h0_0_1_104_8C0_004
  };

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) ^ (a >> 8));
  endfunction

  function automatic int unitBytes(input int code);
    case (code)
      0: return 4; 1: return 1; 2: return 2; 3: return 16;
      4: return 32; 5: return 64; default: return 128;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic initMem();
    for (int a = 0; a < 4096; a++) begin
      memB[a] = pat(a);
      expMem[a] = pat(a);
    end
  endtask

  task automatic putWord(input int a, input logic [31:0] w);
    for (int l = 0; l < 4; l++) memB[a + l] = w[8*l +: 8];
  endtask

  task automatic putDesc(input int a, input int code, input bit sai, input bit dai,
                         input bit link, input bit tie, input int src, input int dst,
                         input int cnt, input int off);
    putWord(a, (32'(sai) << 23) | (32'(dai) << 22) | (32'(code) << 8) |
               (32'(tie) << 1) | 32'(link));
    putWord(a + 4, 32'(src));
    putWord(a + 8, 32'(dst));
    putWord(a + 12, {8'(off), 24'(cnt)});
  endtask

  task automatic model(input int code, input bit sai, input bit dai,
                       input int src, input int dst, input int cnt);
    int ub, bb;
    ub = unitBytes(code);
    bb = (ub < 4) ? ub : 4;
    for (int k = 0; k < cnt * ub; k++)
      expMem[dai ? dst + k : dst + (k % bb)] = pat(sai ? src + k : src + (k % bb));
  endtask

  task automatic compareDst(input string req);
    int mis = 0;
    for (int a = 12'h800; a < 12'hC00; a++) if (memB[a] !== expMem[a]) mis++;
    chk(mis == 0, req, "target bytes mismatched", 32'(mis), 0);
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regSel = sel; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    regSel = sel;
    #1 d = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    int n = 0;
    do begin
      regRead(2'd1, s);
      n++;
    end while (s[0] && n < 4000);
  endtask

  task automatic startAt(input int base);
    wrBase = wrCount;
    regWrite(2'd0, 32'(base));
    regWrite(2'd1, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog run did not finish actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int irq0, w0;
    rstN = 1'b0; regWr = 1'b0; regSel = 2'd0; regWdata = '0;
    initMem();
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R9 reset state
    regRead(2'd1, d); chk(d == 0, "R9", "status after reset", d, 0);
    regRead(2'd0, d); chk(d == 0, "R9", "base after reset", d, 0);
    regRead(2'd2, d); chk(d == 0, "R9", "count after reset", d, 0);
    chk(!irq && !memReq, "R9", "irq/memReq after reset", {irq, memReq}, 0);

    // table of single descriptors
    for (int v = 0; v < NV; v++) begin
      int code, src, dst, cnt;
      bit sai, dai;
      code = int'(VEC[v][47:44]); sai = VEC[v][40]; dai = VEC[v][36];
      src = int'(VEC[v][35:24]); dst = int'(VEC[v][23:12]); cnt = int'(VEC[v][11:0]);
      initMem();
      putDesc(12'h040, code, sai, dai, 1'b0, 1'b1, src, dst, cnt, 0);
      model(code, sai, dai, src, dst, cnt);
      irq0 = irqRises;
      startAt(12'h040);
      waitIdle();
      compareDst((sai && dai) ? "R2" : "R3");
      regRead(2'd1, d); chk(d == 32'h8, "R5", "status at chain end", d, 32'h8);
      chk(irq && irqRises == irq0 + 1, "R5", "single irq at end", 32'(irqRises - irq0), 1);
      if (v == 0) begin
        chk(readLog[0] == 32'h40 && readLog[1] == 32'h44 && readLog[2] == 32'h48 &&
            readLog[3] == 32'h4C, "R1", "descriptor word order", readLog[3], 32'h4C);
        regRead(2'd2, d); chk(d == 0, "R6", "residue after end", d, 0);
      end
    end

    // R4, R11: relative links from the latched base, base rewritten mid-run
    initMem();
    putDesc(12'h040, 0, 1, 1, 1, 1, 12'h100, 12'h800, 2, 2);
    putDesc(12'h060, 1, 1, 1, 1, 1, 12'h111, 12'h821, 3, 4);
    putDesc(12'h080, 2, 1, 1, 0, 1, 12'h122, 12'h842, 2, 0);
    putDesc(12'h320, 0, 1, 1, 0, 1, 12'h100, 12'hA00, 4, 0);
    putDesc(12'h340, 0, 1, 1, 0, 1, 12'h100, 12'hA40, 4, 0);
    model(0, 1, 1, 12'h100, 12'h800, 2);
    model(1, 1, 1, 12'h111, 12'h821, 3);
    model(2, 1, 1, 12'h122, 12'h842, 2);
    irq0 = irqRises;
    startAt(12'h040);
    regWrite(2'd0, 32'h300);
    waitIdle();
    compareDst("R4");
    regRead(2'd0, d); chk(d == 32'h300, "R11", "software base kept", d, 32'h300);
    chk(irqRises == irq0 + 1, "R5", "no irq at linked ends", 32'(irqRises - irq0), 1);

    // R6 residue while a write is held off
    initMem();
    putDesc(12'h040, 0, 1, 1, 0, 1, 12'h104, 12'h810, 5, 0);
    stallAt = 2;
    startAt(12'h040);
    w0 = 0;
    while (!(memReq && memWe && (wrCount - wrBase) == 2) && w0 < 500) begin
      @(negedge clk); w0++;
    end
    regRead(2'd2, d); chk(d == 3, "R6", "residue mid-transfer", d, 3);
    stallAt = -1;
    waitIdle();
    regRead(2'd2, d); chk(d == 0, "R6", "residue after finish", d, 0);

    // R10 zero count
    initMem();
    putDesc(12'h040, 0, 1, 1, 0, 1, 12'h104, 12'h810, 0, 0);
    startAt(12'h040);
    waitIdle();
    chk(wrCount == wrBase, "R10", "writes for zero count", 32'(wrCount - wrBase), 0);
    regRead(2'd1, d); chk(d == 32'h8 && irq, "R10", "zero count completes", d, 32'h8);

    // R5 TIE clear: terminated but silent
    putDesc(12'h040, 0, 1, 1, 0, 0, 12'h104, 12'h810, 1, 0);
    startAt(12'h040);
    waitIdle();
    regRead(2'd1, d); chk(d == 32'h8, "R5", "status with TIE clear", d, 32'h8);
    chk(!irq, "R5", "irq with TIE clear", irq, 0);

    // R7 misaligned source, then invalid unit code
    putDesc(12'h040, 0, 1, 1, 0, 1, 12'h102, 12'h810, 2, 0);
    startAt(12'h040);
    waitIdle();
    regRead(2'd1, d); chk(d == 32'h14 && irq, "R7", "misaligned status", d, 32'h14);
    chk(wrCount == wrBase, "R7", "no data on error", 32'(wrCount - wrBase), 0);
    regWrite(2'd1, 32'd0);
    regRead(2'd1, d); chk(d == 0 && !irq, "R8", "clear after error", d, 0);
    putDesc(12'h040, 7, 1, 1, 0, 1, 12'h100, 12'h800, 1, 0);
    startAt(12'h040);
    waitIdle();
    regRead(2'd1, d); chk(d == 32'h14, "R7", "invalid unit code", d, 32'h14);

    // R5/R8 chain looping to offset 0 never interrupts; stop clears it
    regWrite(2'd1, 32'd0);
    putDesc(12'h040, 0, 1, 1, 1, 1, 12'h100, 12'h800, 2, 0);
    irq0 = irqRises;
    startAt(12'h040);
    repeat (300) @(negedge clk);
    regRead(2'd1, d); chk(d == 32'h1, "R8", "looping chain still running", d, 1);
    chk(!irq && irqRises == irq0, "R5", "looping chain irq", 32'(irqRises - irq0), 0);
    regWrite(2'd1, 32'd0);
    w0 = wrCount;
    repeat (20) @(negedge clk);
    regRead(2'd1, d); chk(d == 0 && !irq && !memReq, "R8", "stop command", d, 0);
    chk(wrCount == w0, "R8", "writes after stop", 32'(wrCount - w0), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule